// File: doc/BRIEF.md
# Hashed Layer-2 Destination Table

This block is the address table of a three-port layer-2 switch. It stores up to 1024 MAC address entries as 128 hashed bins of 8 ways. For each frame the caller gives it the destination MAC. The block answers with a port mask and three more fields: a filter flag, a 3-bit priority and a spanning-tree override. If no entry matches, it answers "unknown" so that the caller floods the frame.

The same engine learns source addresses from received frames and ages out dynamically learned entries in a background sweep. A host port reads and writes any entry directly by index. Entries the host marks static are never aged out and are never replaced by learning.

One controller serves all requests, one at a time. The state machine has these states:
- `S_IDLE` arbitrates among the requests.
- `S_LK_SCAN` walks the eight ways of a lookup, and `S_LK_RESP` presents the answer.
- `S_LN_SCAN` walks the eight ways of a learn, and `S_LN_COMMIT` writes the chosen way.
- `S_HOST` carries out one host access.
- `S_AGE` processes one entry of the sweep.

The transitions are:
- `S_IDLE` goes to `S_LK_SCAN`, `S_HOST`, `S_LN_SCAN` or `S_AGE`, according to the grant.
- Each scan state moves on to its response or commit state after the last way.
- `S_LK_RESP`, `S_LN_COMMIT`, `S_HOST` and `S_AGE` each return to `S_IDLE` after one cycle.

Top module: `l2tbl_engine`

## Requirements
- R1: An entry is 57 bits. Bit 56 is valid, bit 55 is age/override, bit 54 is static, bit 53 is filter, bits 52:50 are priority, bits 49:48 are the port code and bits 47:0 are the MAC. The host index is bin*8+way, and a host read returns the entry last written at that index.
- R2: The bin of a MAC is a 7-bit XOR fold: bin bit j is the XOR of all MAC bits i with i mod 7 == j. A lookup searches only that bin.
- R3: On a hit, `lk_hit` is 1. `lk_fwd` decodes the port code (0 gives 001, 1 gives 010, 2 gives 100, 3 gives 111). `lk_filter` and `lk_prio` are copied from the entry.
- R4: On a miss, `lk_hit` is 0 and `lk_fwd` is 111. Filter, priority and override are all 0.
- R5: `lk_stp_ovr` is bit 55 of a static entry that hits. A dynamic hit reports 0.
- R6: `lk_done` rises exactly 9 cycles (ways + 1) after the cycle of `lk_gnt`, whether the lookup hits or misses and whatever the way.
- R7: A learn of an unknown MAC into a bin with a free way writes valid=1, age=1, static=0, filter=0, priority=0, with the given port.
- R8: A learn of a MAC already held as a dynamic entry updates its port and sets its age to 1. It creates no second copy.
- R9: A learn never changes a static entry.
- R10: When a bin is full, a learn replaces the lowest dynamic way whose age bit is 0. If there is no such way, the learn is dropped.
- R11: A pulse on `age_tick` starts a sweep over all entries. A dynamic entry with age 1 goes to age 0, and one with age 0 becomes invalid. Static entries are untouched. A lookup hit on a dynamic entry sets its age to 1.
- R12: Grants follow a fixed order: lookup first, then host, then learn, then the sweep. At most one grant is given per cycle.
- R13: `h_done` is high in the cycle after `h_gnt`. A host write of valid=0 deletes the entry.
- R14: After reset every entry is invalid and no grant or done output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request, held until granted |
| lk_mac | input | 48 | Destination MAC to search |
| lk_gnt | output | 1 | Lookup accepted this cycle |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Entry found |
| lk_fwd | output | 3 | Destination port mask |
| lk_filter | output | 1 | Drop the frame |
| lk_prio | output | 3 | Entry priority |
| lk_stp_ovr | output | 1 | Bypass spanning-tree port state |
| ln_req | input | 1 | Learn request, held until granted |
| ln_mac | input | 48 | Source MAC to learn |
| ln_port | input | 2 | Ingress port code |
| ln_gnt | output | 1 | Learn accepted this cycle |
| ln_done | output | 1 | Learn committed |
| age_tick | input | 1 | Start an aging sweep |
| h_req | input | 1 | Host access request, held until granted |
| h_wr | input | 1 | 1 write, 0 read |
| h_idx | input | 10 | Entry index (bin*8+way) |
| h_wdata | input | 57 | Entry to write |
| h_gnt | output | 1 | Host access accepted this cycle |
| h_done | output | 1 | Host access done, read data valid |
| h_rdata | output | 57 | Entry read |

## Verification
A wrong scan counter or a hit captured from the wrong way shows at the ports within one lookup. It appears as a wrong port mask or priority, or as a `lk_done` that misses its fixed ninth cycle. A wrong learn or commit decision is seen on the next lookup or host read of that bin. Such errors include a duplicate, an overwritten static entry or the wrong victim way. A fault in the age update shows only after one or two full sweeps, about 2k cycles each, when the host reads the age bit or finds the entry invalid. Grant-order faults show in the same cycle as competing requests.

// File: rtl/l2tbl_pkg.sv
package l2tbl_pkg;

    localparam int MAC_W = 48;
    localparam int ENT_W = 57;

    typedef struct packed {
        logic             valid;
        logic             age_ovr;
        logic             stat;
        logic             filt;
        logic [2:0]       prio;
        logic [1:0]       port;
        logic [MAC_W-1:0] mac;
    } l2_entry_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LK_SCAN,
        S_LK_RESP,
        S_LN_SCAN,
        S_LN_COMMIT,
        S_HOST,
        S_AGE
    } eng_state_t;

    function automatic logic [2:0] port_mask(input logic [1:0] code);
        logic [2:0] m;
        unique case (code)
            2'd0:    m = 3'b001;
            2'd1:    m = 3'b010;
            2'd2:    m = 3'b100;
            default: m = 3'b111;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/l2tbl_hash.sv
module l2tbl_hash #(
    parameter int MAC_W = 48,
    parameter int BIN_W = 7
) (
    input  logic [MAC_W-1:0] mac,
    output logic [BIN_W-1:0] bin
);

    for (genvar j = 0; j < BIN_W; j++) begin : g_fold
        always_comb begin
            bin[j] = 1'b0;
            for (int i = 0; i < MAC_W; i++) begin
                if ((i % BIN_W) == j) bin[j] = bin[j] ^ mac[i];
            end
        end
    end

endmodule

// File: rtl/l2tbl_store.sv
module l2tbl_store
    import l2tbl_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    output l2_entry_t        rd_ent,
    input  logic             we,
    input  l2_entry_t        wr_ent
);

    localparam int NENT  = 1 << IDX_W;
    localparam int BODY_W = ENT_W - 1;

    logic [NENT-1:0]   valid_q;
    logic [BODY_W-1:0] body_q [NENT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (we) begin
            valid_q[idx] <= wr_ent.valid;
        end
    end

    always_ff @(posedge clk) begin
        if (we) body_q[idx] <= wr_ent[BODY_W-1:0];
    end

    assign rd_ent = l2_entry_t'({valid_q[idx], body_q[idx]});

endmodule

// File: rtl/l2tbl_engine.sv
module l2tbl_engine
    import l2tbl_pkg::*;
#(
    parameter int BIN_W = 7,
    parameter int WAY_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lk_req,
    input  logic [47:0]            lk_mac,
    output logic                   lk_gnt,
    output logic                   lk_done,
    output logic                   lk_hit,
    output logic [2:0]             lk_fwd,
    output logic                   lk_filter,
    output logic [2:0]             lk_prio,
    output logic                   lk_stp_ovr,
    input  logic                   ln_req,
    input  logic [47:0]            ln_mac,
    input  logic [1:0]             ln_port,
    output logic                   ln_gnt,
    output logic                   ln_done,
    input  logic                   age_tick,
    input  logic                   h_req,
    input  logic                   h_wr,
    input  logic [BIN_W+WAY_W-1:0] h_idx,
    input  logic [56:0]            h_wdata,
    output logic                   h_gnt,
    output logic                   h_done,
    output logic [56:0]            h_rdata
);

    localparam int NWAYS = 1 << WAY_W;
    localparam int IDX_W = BIN_W + WAY_W;
    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(NWAYS - 1);

    eng_state_t state_q, state_d;

    logic [WAY_W-1:0] way_q;
    logic [BIN_W-1:0] bin_q;
    logic [47:0]      key_q;
    logic [1:0]       lport_q;
    logic             hit_q;
    l2_entry_t        hent_q;
    logic             m_found_q, m_stat_q, e_found_q, s_found_q;
    logic [WAY_W-1:0] m_way_q, e_way_q, s_way_q;
    logic             age_pend_q;
    logic [IDX_W-1:0] age_ptr_q;

    logic [BIN_W-1:0] lk_bin, ln_bin;
    logic             idle, g_lk, g_h, g_ln, g_age;
    logic [IDX_W-1:0] tbl_idx;
    l2_entry_t        cur, wr_ent;
    logic             tbl_we, match;
    logic [WAY_W-1:0] cway;

    l2tbl_hash #(.MAC_W(48), .BIN_W(BIN_W)) i_hash_lk (.mac(lk_mac), .bin(lk_bin));
    l2tbl_hash #(.MAC_W(48), .BIN_W(BIN_W)) i_hash_ln (.mac(ln_mac), .bin(ln_bin));

    l2tbl_store #(.IDX_W(IDX_W)) i_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx    (tbl_idx),
        .rd_ent (cur),
        .we     (tbl_we),
        .wr_ent (wr_ent)
    );

    // Fixed grant order: lookup, host, learn, aging sweep.
    assign idle  = (state_q == S_IDLE);
    assign g_lk  = idle && lk_req;
    assign g_h   = idle && !lk_req && h_req;
    assign g_ln  = idle && !lk_req && !h_req && ln_req;
    assign g_age = idle && !lk_req && !h_req && !ln_req && age_pend_q;

    assign match = cur.valid && (cur.mac == key_q);

    // Way chosen at commit: existing entry, else free way, else stale dynamic.
    always_comb begin
        if (m_found_q)      cway = m_way_q;
        else if (e_found_q) cway = e_way_q;
        else                cway = s_way_q;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (g_lk)       state_d = S_LK_SCAN;
                else if (g_h)   state_d = S_HOST;
                else if (g_ln)  state_d = S_LN_SCAN;
                else if (g_age) state_d = S_AGE;
            end
            S_LK_SCAN:   if (way_q == LAST_WAY) state_d = S_LK_RESP;
            S_LN_SCAN:   if (way_q == LAST_WAY) state_d = S_LN_COMMIT;
            S_LK_RESP,
            S_LN_COMMIT,
            S_HOST,
            S_AGE:       state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // Table access and outputs
    always_comb begin
        tbl_idx = '0;
        tbl_we  = 1'b0;
        wr_ent  = cur;
        unique case (state_q)
            S_LK_SCAN: begin
                tbl_idx = {bin_q, way_q};
                if (match && !cur.stat && !hit_q) begin
                    tbl_we         = 1'b1;
                    wr_ent.age_ovr = 1'b1;
                end
            end
            S_LN_SCAN: tbl_idx = {bin_q, way_q};
            S_LN_COMMIT: begin
                tbl_idx = {bin_q, cway};
                if (m_found_q) begin
                    if (!m_stat_q) begin
                        tbl_we         = 1'b1;
                        wr_ent.port    = lport_q;
                        wr_ent.age_ovr = 1'b1;
                    end
                end else if (e_found_q || s_found_q) begin
                    tbl_we = 1'b1;
                    wr_ent = '{valid: 1'b1, age_ovr: 1'b1, stat: 1'b0, filt: 1'b0,
                               prio: 3'd0, port: lport_q, mac: key_q};
                end
            end
            S_HOST: begin
                tbl_idx = h_idx;
                if (h_wr) begin
                    tbl_we = 1'b1;
                    wr_ent = l2_entry_t'(h_wdata);
                end
            end
            S_AGE: begin
                tbl_idx = age_ptr_q;
                if (cur.valid && !cur.stat) begin
                    tbl_we = 1'b1;
                    if (cur.age_ovr) wr_ent.age_ovr = 1'b0;
                    else             wr_ent.valid   = 1'b0;
                end
            end
            default: ;
        endcase

        lk_gnt  = g_lk;
        ln_gnt  = g_ln;
        h_gnt   = g_h;
        lk_done = (state_q == S_LK_RESP);
        ln_done = (state_q == S_LN_COMMIT);
        h_done  = (state_q == S_HOST);
        h_rdata = h_done ? cur : '0;
        lk_hit  = hit_q;
        if (hit_q) begin
            lk_fwd     = port_mask(hent_q.port);
            lk_filter  = hent_q.filt;
            lk_prio    = hent_q.prio;
            lk_stp_ovr = hent_q.stat && hent_q.age_ovr;
        end else begin
            lk_fwd     = 3'b111;
            lk_filter  = 1'b0;
            lk_prio    = 3'd0;
            lk_stp_ovr = 1'b0;
        end
    end

    // Scan, capture and sweep registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            way_q      <= '0;
            bin_q      <= '0;
            key_q      <= '0;
            lport_q    <= '0;
            hit_q      <= 1'b0;
            hent_q     <= '0;
            m_found_q  <= 1'b0;
            m_stat_q   <= 1'b0;
            m_way_q    <= '0;
            e_found_q  <= 1'b0;
            e_way_q    <= '0;
            s_found_q  <= 1'b0;
            s_way_q    <= '0;
            age_pend_q <= 1'b0;
            age_ptr_q  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    way_q <= '0;
                    if (g_lk || g_ln) begin
                        key_q     <= g_lk ? lk_mac : ln_mac;
                        bin_q     <= g_lk ? lk_bin : ln_bin;
                        lport_q   <= ln_port;
                        hit_q     <= 1'b0;
                        m_found_q <= 1'b0;
                        e_found_q <= 1'b0;
                        s_found_q <= 1'b0;
                    end
                end
                S_LK_SCAN: begin
                    way_q <= way_q + 1'b1;
                    if (match && !hit_q) begin
                        hit_q  <= 1'b1;
                        hent_q <= cur;
                    end
                end
                S_LN_SCAN: begin
                    way_q <= way_q + 1'b1;
                    if (match && !m_found_q) begin
                        m_found_q <= 1'b1;
                        m_way_q   <= way_q;
                        m_stat_q  <= cur.stat;
                    end
                    if (!cur.valid && !e_found_q) begin
                        e_found_q <= 1'b1;
                        e_way_q   <= way_q;
                    end
                    if (cur.valid && !cur.stat && !cur.age_ovr && !s_found_q) begin
                        s_found_q <= 1'b1;
                        s_way_q   <= way_q;
                    end
                end
                S_AGE: begin
                    age_ptr_q <= age_ptr_q + 1'b1;
                    if (&age_ptr_q) age_pend_q <= 1'b0;
                end
                default: ;
            endcase
            if (age_tick) age_pend_q <= 1'b1;
        end
    end

endmodule

// File: rtl/l2tbl_engine_chk.sv
module l2tbl_engine_chk #(
    parameter int NWAYS = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       lk_req,
    input logic       h_req,
    input logic       ln_req,
    input logic       lk_gnt,
    input logic       ln_gnt,
    input logic       h_gnt,
    input logic       lk_done,
    input logic       ln_done,
    input logic       h_done,
    input logic       lk_hit,
    input logic [2:0] lk_fwd,
    input logic       lk_filter,
    input logic [2:0] lk_prio,
    input logic       lk_stp_ovr
);

    logic [15:0] lat_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              lat_q <= '0;
        else if (lk_gnt)         lat_q <= 16'd1;
        else if (lk_done)        lat_q <= '0;
        else if (lat_q != 16'd0) lat_q <= lat_q + 16'd1;
    end

    p_miss_flood_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done && !lk_hit |-> lk_fwd == 3'b111 && !lk_filter && lk_prio == 3'd0 && !lk_stp_ovr);

    p_fwd_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done && lk_hit |-> ($countones(lk_fwd) == 1 || lk_fwd == 3'b111));

    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done |-> lat_q == 16'(NWAYS + 1));

    p_host_next_r13: assert property (@(posedge clk) disable iff (!rst_n)
        h_gnt |=> h_done);

    p_one_grant_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lk_gnt, ln_gnt, h_gnt}));

    p_order_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ln_gnt |-> !lk_req && !h_req) and (h_gnt |-> !lk_req));

    p_gnt_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_gnt |-> lk_req) and (h_gnt |-> h_req) and (ln_gnt |-> ln_req));

    p_done_single_r14: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lk_done, ln_done, h_done}));

endmodule

bind l2tbl_engine l2tbl_engine_chk #(.NWAYS(NWAYS)) i_chk (.*);

// File: tb/test_l2tbl_engine.sv
module test_l2tbl_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [47:0] lk_mac = '0;
    logic        lk_gnt, lk_done, lk_hit, lk_filter, lk_stp_ovr;
    logic [2:0]  lk_fwd, lk_prio;
    logic        ln_req = 1'b0;
    logic [47:0] ln_mac = '0;
    logic [1:0]  ln_port = '0;
    logic        ln_gnt, ln_done;
    logic        age_tick = 1'b0;
    logic        h_req = 1'b0;
    logic        h_wr = 1'b0;
    logic [9:0]  h_idx = '0;
    logic [56:0] h_wdata = '0;
    logic        h_gnt, h_done;
    logic [56:0] h_rdata;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    l2tbl_engine i_l2tbl_engine (.*);

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] bin_of(input logic [47:0] m);
        logic [6:0] b = '0;
        for (int i = 0; i < 48; i++) b[i % 7] = b[i % 7] ^ m[i];
        return b;
    endfunction

    function automatic logic [56:0] mk(input logic a, input logic s, input logic f,
                                       input logic [2:0] p, input logic [1:0] pt, input logic [47:0] m);
        return {1'b1, a, s, f, p, pt, m};
    endfunction

    function automatic logic [47:0] coll(input logic [47:0] base, input int k);
        logic [47:0] d = 48'(k & 127);
        return base ^ d ^ (d << 7);
    endfunction

    logic        r_hit, r_filt, r_ovr;
    logic [2:0]  r_fwd, r_prio;
    int          r_lat;

    task automatic lookup(input logic [47:0] m);
        lk_mac = m;
        lk_req = 1'b1;
        #1;
        while (!lk_gnt) begin @(negedge clk); #1; end
        @(negedge clk);
        lk_req = 1'b0;
        r_lat = 1;
        #1;
        while (!lk_done) begin @(negedge clk); #1; r_lat++; end
        r_hit = lk_hit; r_fwd = lk_fwd; r_filt = lk_filter; r_prio = lk_prio; r_ovr = lk_stp_ovr;
    endtask

    task automatic learn(input logic [47:0] m, input logic [1:0] pt);
        ln_mac = m;
        ln_port = pt;
        ln_req = 1'b1;
        #1;
        while (!ln_gnt) begin @(negedge clk); #1; end
        @(negedge clk);
        ln_req = 1'b0;
        #1;
        while (!ln_done) begin @(negedge clk); #1; end
    endtask

    task automatic host_op(input logic wr, input logic [9:0] idx, input logic [56:0] d,
                           output logic [56:0] q);
        h_wr = wr; h_idx = idx; h_wdata = d; h_req = 1'b1;
        #1;
        while (!h_gnt) begin @(negedge clk); #1; end
        @(negedge clk);
        h_req = 1'b0;
        #1;
        chk("R13", "h_done one cycle after grant", 64'(h_done), 64'd1);
        q = h_rdata;
    endtask

    task automatic find_entry(input logic [47:0] m, output logic [56:0] e, output int cnt);
        logic [56:0] q;
        cnt = 0; e = '0;
        for (int w = 0; w < 8; w++) begin
            host_op(1'b0, {bin_of(m), 3'(w)}, '0, q);
            if (q[56] && q[47:0] == m) begin cnt++; e = q; end
        end
    endtask

    task automatic sweep();
        @(negedge clk); age_tick = 1'b1;
        @(negedge clk); age_tick = 1'b0;
        repeat (2200) @(negedge clk);
        #1;
    endtask

    // {mac, hit, fwd, filter, prio, ovr}
    localparam int NV = 6;
    localparam logic [56:0] VEC [NV] = '{
        {48'h0011_2233_4455, 1'b1, 3'b001, 1'b0, 3'd5, 1'b1},
        {48'h00AA_BBCC_DDEE, 1'b1, 3'b111, 1'b1, 3'd2, 1'b0},
        {48'h0102_0304_0506, 1'b1, 3'b100, 1'b0, 3'd7, 1'b0},
        {48'h0A0B_0C0D_0E0F, 1'b1, 3'b010, 1'b0, 3'd0, 1'b1},
        {48'h0DEA_D0BE_EF00, 1'b0, 3'b111, 1'b0, 3'd0, 1'b0},
        {48'h0077_6655_4433, 1'b0, 3'b111, 1'b0, 3'd0, 1'b0}
    };

    localparam logic [47:0] S0 = 48'h0011_2233_4455;
    localparam logic [47:0] S1 = 48'h00AA_BBCC_DDEE;
    localparam logic [47:0] S2 = 48'h0102_0304_0506;
    localparam logic [47:0] S3 = 48'h0A0B_0C0D_0E0F;
    localparam logic [47:0] WB = 48'h0077_6655_4433;
    localparam logic [47:0] L1 = 48'h0200_0000_1111;
    localparam logic [47:0] L2 = 48'h0200_0000_2222;
    localparam logic [47:0] CB = 48'h0000_5A5A_1234;

    initial begin
        repeat (1000000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [56:0] q, e;
        int          cnt;
        int          mark;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // R14: quiet outputs and empty table after reset
        chk("R14", "grants/dones idle", 64'({lk_gnt, ln_gnt, h_gnt, lk_done, ln_done, h_done}), 64'd0);
        host_op(1'b0, 10'd0, '0, q);
        chk("R14", "entry 0 invalid", 64'(q[56]), 64'd0);
        host_op(1'b0, 10'd1023, '0, q);
        chk("R14", "entry 1023 invalid", 64'(q[56]), 64'd0);

        // R1: static entries written at bin*8+way
        host_op(1'b1, {bin_of(S0), 3'd0}, mk(1'b1, 1'b1, 1'b0, 3'd5, 2'd0, S0), q);
        host_op(1'b1, {bin_of(S1), 3'd1}, mk(1'b0, 1'b1, 1'b1, 3'd2, 2'd3, S1), q);
        host_op(1'b1, {bin_of(S2), 3'd5}, mk(1'b0, 1'b1, 1'b0, 3'd7, 2'd2, S2), q);
        host_op(1'b1, {bin_of(S3), 3'd2}, mk(1'b1, 1'b1, 1'b0, 3'd0, 2'd1, S3), q);
        // R2: entry placed one bin off must not be found
        host_op(1'b1, {bin_of(WB) + 7'd1, 3'd7}, mk(1'b0, 1'b1, 1'b0, 3'd1, 2'd1, WB), q);
        host_op(1'b0, {bin_of(S2), 3'd5}, '0, q);
        chk("R1", "host read back", 64'(q), 64'(mk(1'b0, 1'b1, 1'b0, 3'd7, 2'd2, S2)));

        // R3 R4 R5 R6 R2: vector table
        for (int v = 0; v < NV; v++) begin
            lookup(VEC[v][56:9]);
            chk("R3", "hit", 64'(r_hit), 64'(VEC[v][8]));
            chk("R3", "fwd mask", 64'(r_fwd), 64'(VEC[v][7:5]));
            chk("R3", "filter", 64'(r_filt), 64'(VEC[v][4]));
            chk("R3", "prio", 64'(r_prio), 64'(VEC[v][3:1]));
            chk("R5", "stp override", 64'(r_ovr), 64'(VEC[v][0]));
            chk("R6", "latency", 64'(r_lat), 64'd9);
            if (!VEC[v][8]) chk("R4", "miss floods", 64'(r_fwd), 64'd7);
            if (v == 5) chk("R2", "wrong bin misses", 64'(r_hit), 64'd0);
        end

        // R7: learn a new address
        learn(L1, 2'd1);
        lookup(L1);
        chk("R7", "learned hit fwd", 64'({r_hit, r_fwd}), 64'({1'b1, 3'b010}));
        chk("R5", "dynamic no override", 64'(r_ovr), 64'd0);
        find_entry(L1, e, cnt);
        chk("R7", "learned entry fields", 64'(e), 64'(mk(1'b1, 1'b0, 1'b0, 3'd0, 2'd1, L1)));

        // R8: relearn on another port
        learn(L1, 2'd2);
        lookup(L1);
        chk("R8", "port updated", 64'(r_fwd), 64'b100);
        find_entry(L1, e, cnt);
        chk("R8", "single copy", 64'(cnt), 64'd1);

        // R9: learning a static address changes nothing
        learn(S0, 2'd2);
        lookup(S0);
        chk("R9", "static fwd kept", 64'({r_fwd, r_ovr}), 64'({3'b001, 1'b1}));
        host_op(1'b0, {bin_of(S0), 3'd0}, '0, q);
        chk("R9", "static entry kept", 64'(q), 64'(mk(1'b1, 1'b1, 1'b0, 3'd5, 2'd0, S0)));

        // R11: aging
        learn(L2, 2'd0);
        sweep();
        find_entry(L1, e, cnt);
        chk("R11", "first sweep clears age", 64'({cnt[0], e[55]}), 64'({1'b1, 1'b0}));
        lookup(L2);
        chk("R11", "aged entry still hits", 64'(r_hit), 64'd1);
        sweep();
        find_entry(L1, e, cnt);
        chk("R11", "second sweep removes", 64'(cnt), 64'd0);
        lookup(L1);
        chk("R11", "removed entry misses", 64'(r_hit), 64'd0);
        find_entry(L2, e, cnt);
        chk("R11", "refreshed entry survives", 64'({cnt[0], e[55]}), 64'({1'b1, 1'b0}));
        host_op(1'b0, {bin_of(S0), 3'd0}, '0, q);
        chk("R11", "static untouched by sweeps", 64'(q), 64'(mk(1'b1, 1'b1, 1'b0, 3'd5, 2'd0, S0)));

        // R13: delete by writing valid=0
        host_op(1'b1, {bin_of(S3), 3'd2}, '0, q);
        lookup(S3);
        chk("R13", "deleted entry misses", 64'(r_hit), 64'd0);

        // R10: full bin replacement
        for (int w = 0; w < 8; w++) host_op(1'b1, {bin_of(CB), 3'(w)}, '0, q);
        for (int k = 0; k < 8; k++) learn(coll(CB, k), 2'(k % 3));
        learn(coll(CB, 8), 2'd3);
        lookup(coll(CB, 8));
        chk("R10", "learn dropped when all fresh", 64'(r_hit), 64'd0);
        sweep();
        lookup(coll(CB, 3));
        learn(coll(CB, 8), 2'd3);
        lookup(coll(CB, 8));
        chk("R10", "replacement learned", 64'({r_hit, r_fwd}), 64'({1'b1, 3'b111}));
        lookup(coll(CB, 0));
        chk("R10", "lowest stale way evicted", 64'(r_hit), 64'd0);
        host_op(1'b0, {bin_of(CB), 3'd0}, '0, q);
        chk("R10", "way 0 holds new entry", 64'(q), 64'(mk(1'b1, 1'b0, 1'b0, 3'd0, 2'd3, coll(CB, 8))));
        lookup(coll(CB, 3));
        chk("R10", "refreshed way kept", 64'(r_hit), 64'd1);

        // R12: grant order under simultaneous requests
        @(negedge clk);
        lk_mac = S1; lk_req = 1'b1;
        h_wr = 1'b0; h_idx = 10'd0; h_req = 1'b1;
        ln_mac = L1; ln_port = 2'd1; ln_req = 1'b1;
        #1;
        while (!(lk_gnt || h_gnt || ln_gnt)) begin @(negedge clk); #1; end
        chk("R12", "lookup wins", 64'({lk_gnt, h_gnt, ln_gnt}), 64'b100);
        @(negedge clk); lk_req = 1'b0; #1;
        mark = 0;
        while (!(h_gnt || ln_gnt) && mark < 50) begin @(negedge clk); #1; mark++; end
        chk("R12", "host before learn", 64'({h_gnt, ln_gnt}), 64'b10);
        @(negedge clk); h_req = 1'b0; #1;
        mark = 0;
        while (!ln_gnt && mark < 50) begin @(negedge clk); #1; mark++; end
        chk("R12", "learn granted last", 64'(ln_gnt), 64'd1);
        @(negedge clk); ln_req = 1'b0;
        repeat (20) @(negedge clk);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule